// File: doc/BRIEF.md
# 64-bit Alarm Timer with Snapshot Read

A single free-running time base with a 64-bit counter, a programmable clock prescaler, an up/down direction and a 64-bit alarm compare. Software talks to it through a flat register port of 32-bit words. The counter is never read directly: a write to a trigger address freezes a copy of the live count into a low/high register pair, so the two halves always come from the same instant.

The counter is also never written directly. Software stages a 64-bit start value as two halves and then writes a second trigger address, which copies the staged value into the counter. When the count reaches the alarm value while the alarm is armed, the timer records an interrupt. It can also reload itself from the staged value, which makes it a periodic timer. The interrupt has raw, enable, masked-status and write-one-to-clear views. It drives a level output and a one-cycle edge output.

Register addresses (4-bit): 0 control, 1 prescale, 2 snapshot trigger, 3 snapshot low, 4 snapshot high, 5 alarm low, 6 alarm high, 7 start low, 8 start high, 9 reload trigger, 10 interrupt raw, 11 interrupt enable, 12 interrupt status, 13 interrupt clear. Control bits: 0 run, 1 count up (0 = down), 2 auto-reload, 3 alarm armed, 4 level output enable, 5 edge output enable.

Top module: `alarm_timer64`

## Requirements
- R1: After reset, snapshot low/high (addresses 3, 4), interrupt raw (address 10), irq_level and irq_edge all read 0.
- R2: While run (control bit 0) is set, the counter takes one step every N clocks, where N is the prescale register (address 1). A prescale of 0 means N = 2^DIV_W, and a prescale of 1 means a step on every clock. The first step comes N clocks after run is set.
- R3: Writing any data to address 9 loads the staged start value (addresses 7, 8) into the counter on that edge. This load takes priority over a step.
- R4: With control bit 1 set, each step adds one; with it clear, each step subtracts one. The count wraps modulo 2^64 and carries or borrows across the 32-bit halves.
- R5: Writing any data to address 2 copies the live count into the snapshot registers. They keep that value until the next write to address 2, whatever the counter does in between.
- R6: With the alarm armed (control bit 3) and auto-reload (control bit 2) set, a step taken while the count equals the alarm value (addresses 5, 6) loads the start value instead of stepping. The armed bit stays set.
- R7: Without auto-reload, such a step advances the counter normally, raises the alarm once and clears the armed bit, as control reads back. No further alarm follows until software re-arms.
- R8: An alarm sets interrupt raw bit 0, and raw stays set until a write of 1 to bit 0 of address 13. Status (address 12) is raw AND enable (address 11, bit 0). irq_level is status AND control bit 4.
- R9: irq_edge pulses high for one clock per alarm, only when control bit 5 and the interrupt enable are both set.
- R10: While run is clear the count holds, and snapshot and reload writes still take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| irq_level | output | 1 | Level interrupt |
| irq_edge | output | 1 | One-cycle pulse interrupt |

## Verification
The bench builds the timer with DIV_W = 4, so all sixteen prescale settings can be swept, including the zero code that stands for 16, and the step count in each is checked against an arithmetic floor division. The counter stays 64 bits wide. This keeps the carry and borrow across the halves and the wrap at zero in reach within a few steps, by staging start values next to those boundaries. Periodic alarms are counted over a window and checked against the window length divided by the reload period.

// File: rtl/timer_pkg.sv
// Package: register addresses and control bit positions shared by the
// timer top level and anything that drives its register port.
package timer_pkg;
    typedef enum logic [3:0] {
        ADR_CTRL     = 4'd0,
        ADR_PRESCALE = 4'd1,
        ADR_SNAP_TRG = 4'd2,
        ADR_SNAP_LO  = 4'd3,
        ADR_SNAP_HI  = 4'd4,
        ADR_ALM_LO   = 4'd5,
        ADR_ALM_HI   = 4'd6,
        ADR_START_LO = 4'd7,
        ADR_START_HI = 4'd8,
        ADR_LOAD_TRG = 4'd9,
        ADR_IRQ_RAW  = 4'd10,
        ADR_IRQ_EN   = 4'd11,
        ADR_IRQ_STAT = 4'd12,
        ADR_IRQ_CLR  = 4'd13
    } tmr_addr_e;

    localparam int CB_RUN   = 0;
    localparam int CB_UP    = 1;
    localparam int CB_AUTO  = 2;
    localparam int CB_ARM   = 3;
    localparam int CB_LVLIE = 4;
    localparam int CB_EDGIE = 5;
endpackage

// File: rtl/tm_prescale.sv
// Prescaler: emits a one-clock tick every N clocks while run is high.
// Assumes div == 0 stands for 2^DIV_W. The phase restarts when run is
// low or when restart (a counter reload) is asserted.
module tm_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] phase;
    logic [CW-1:0] limit;

    // Decode the effective period, mapping zero to the full range.
    always_comb begin
        limit = (div == '0) ? (CW'(1) << DIV_W) : CW'(div);
        tick  = run && (phase == limit - CW'(1));
    end

    // Phase counter that wraps on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                       phase <= '0;
        else if (!run || restart || tick) phase <= '0;
        else                              phase <= phase + CW'(1);
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit > CW'(1)) |=> !tick);
endmodule

// File: rtl/tm_count_core.sv
// Counter core: the 64-bit count, its alarm compare and the armed flag.
// Assumes tick is at most one clock wide. Reload requests override steps.
module tm_count_core #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             count_up,
    input  logic             auto_reload,
    input  logic             reload_req,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] alarm_val,
    input  logic             arm_wr,
    input  logic             arm_wr_val,
    output logic [CNT_W-1:0] count,
    output logic             armed,
    output logic             alarm_evt
);
    logic [CNT_W-1:0] stepped;

    // Next value for a plain step and the alarm hit.
    always_comb begin
        stepped   = count_up ? count + CNT_W'(1) : count - CNT_W'(1);
        alarm_evt = tick && armed && (count == alarm_val);
    end

    // Count register: reload first, then auto-reload on alarm, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)                         count <= '0;
        else if (reload_req)                count <= start_val;
        else if (alarm_evt && auto_reload)  count <= start_val;
        else if (tick)                      count <= stepped;
    end

    // Armed flag: software writes it, a one-shot alarm clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                         armed <= 1'b0;
        else if (arm_wr)                    armed <= arm_wr_val;
        else if (alarm_evt && !auto_reload) armed <= 1'b0;
    end

    // R3
    reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> count == $past(start_val));
    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reload_req) |=> $stable(count));
    // R7
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt && !auto_reload && !arm_wr) |=> !armed);
    // R6
    periodic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt && auto_reload && !reload_req) |=> (armed && count == $past(start_val)));
endmodule

// File: rtl/tm_irq.sv
// Interrupt unit: sticky raw bit, enable, masked status and two outputs.
// Assumes a new alarm wins over a clear arriving in the same clock.
module tm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ie_wr,
    input  logic ie_val,
    input  logic clr_wr,
    input  logic clr_bit,
    input  logic lvl_ie,
    input  logic edge_ie,
    output logic raw,
    output logic ie,
    output logic stat,
    output logic irq_level,
    output logic irq_edge
);
    // Sticky raw flag with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  raw <= 1'b0;
        else if (evt)                raw <= 1'b1;
        else if (clr_wr && clr_bit)  raw <= 1'b0;
    end

    // Enable bit held for software.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= 1'b0;
        else if (ie_wr) ie <= ie_val;
    end

    // One-clock pulse per alarm, gated by both enables.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_edge <= 1'b0;
        else        irq_edge <= evt && edge_ie && ie;
    end

    // Masked status and level output.
    always_comb begin
        stat      = raw && ie;
        irq_level = stat && lvl_ie;
    end

    // R8
    raw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> raw);
    // R9
    edge_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_edge |-> $past(evt && edge_ie && ie));
endmodule

// File: rtl/alarm_timer64.sv
// Top: register file around the prescaler, counter core and interrupt
// unit. Assumes single-cycle writes; reads are combinational on rd_addr.
module alarm_timer64
    import timer_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [3:0]        rd_addr,
    output logic [HALF_W-1:0] rd_data,
    output logic              irq_level,
    output logic              irq_edge
);
    localparam int CNT_W = 2 * HALF_W;

    logic             run_q, up_q, auto_q, lvlie_q, edgie_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] alarm_q, start_q, snap_q, count;
    logic             tick, armed, alarm_evt;
    logic             raw, ie, stat;
    logic             wr_ctrl, wr_load, wr_snap;

    // Decode the strobes that feed submodules.
    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
        wr_load = wr_en && (wr_addr == ADR_LOAD_TRG);
        wr_snap = wr_en && (wr_addr == ADR_SNAP_TRG);
    end

    // Configuration, alarm and start registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {run_q, up_q, auto_q, lvlie_q, edgie_q} <= '0;
            div_q   <= '0;
            alarm_q <= '0;
            start_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    run_q   <= wr_data[CB_RUN];
                    up_q    <= wr_data[CB_UP];
                    auto_q  <= wr_data[CB_AUTO];
                    lvlie_q <= wr_data[CB_LVLIE];
                    edgie_q <= wr_data[CB_EDGIE];
                end
                ADR_PRESCALE: div_q                    <= wr_data[DIV_W-1:0];
                ADR_ALM_LO:   alarm_q[HALF_W-1:0]      <= wr_data;
                ADR_ALM_HI:   alarm_q[CNT_W-1:HALF_W]  <= wr_data;
                ADR_START_LO: start_q[HALF_W-1:0]      <= wr_data;
                ADR_START_HI: start_q[CNT_W-1:HALF_W]  <= wr_data;
                default: ;
            endcase
        end
    end

    // Snapshot of the live count on a trigger write.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (wr_snap) snap_q <= count;
    end

    tm_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .restart(wr_load),
        .div(div_q), .tick(tick)
    );

    tm_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count_up(up_q),
        .auto_reload(auto_q), .reload_req(wr_load), .start_val(start_q),
        .alarm_val(alarm_q), .arm_wr(wr_ctrl), .arm_wr_val(wr_data[CB_ARM]),
        .count(count), .armed(armed), .alarm_evt(alarm_evt)
    );

    tm_irq u_irq (
        .clk(clk), .rst_n(rst_n), .evt(alarm_evt),
        .ie_wr(wr_en && (wr_addr == ADR_IRQ_EN)), .ie_val(wr_data[0]),
        .clr_wr(wr_en && (wr_addr == ADR_IRQ_CLR)), .clr_bit(wr_data[0]),
        .lvl_ie(lvlie_q), .edge_ie(edgie_q),
        .raw(raw), .ie(ie), .stat(stat),
        .irq_level(irq_level), .irq_edge(irq_edge)
    );

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL: begin
                rd_data[CB_RUN]   = run_q;
                rd_data[CB_UP]    = up_q;
                rd_data[CB_AUTO]  = auto_q;
                rd_data[CB_ARM]   = armed;
                rd_data[CB_LVLIE] = lvlie_q;
                rd_data[CB_EDGIE] = edgie_q;
            end
            ADR_PRESCALE: rd_data[DIV_W-1:0] = div_q;
            ADR_SNAP_LO:  rd_data = snap_q[HALF_W-1:0];
            ADR_SNAP_HI:  rd_data = snap_q[CNT_W-1:HALF_W];
            ADR_ALM_LO:   rd_data = alarm_q[HALF_W-1:0];
            ADR_ALM_HI:   rd_data = alarm_q[CNT_W-1:HALF_W];
            ADR_START_LO: rd_data = start_q[HALF_W-1:0];
            ADR_START_HI: rd_data = start_q[CNT_W-1:HALF_W];
            ADR_IRQ_RAW:  rd_data[0] = raw;
            ADR_IRQ_EN:   rd_data[0] = ie;
            ADR_IRQ_STAT: rd_data[0] = stat;
            default: ;
        endcase
    end

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_snap |=> $stable(snap_q));
endmodule

// File: tb/alarm_timer64_bench.sv
module alarm_timer64_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_level, irq_edge;

    int checks = 0;
    int fails = 0;
    int edge_cnt = 0;
    bit done = 0;

    alarm_timer64 #(.DIV_W(4), .HALF_W(32)) u_alarm_timer64 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_level(irq_level), .irq_edge(irq_edge)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (rst_n && irq_edge) edge_cnt++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a; #1;
        d = rd_data;
    endtask

    task automatic snap(output logic [63:0] v);
        logic [31:0] lo, hi;
        wr(4'd2, 32'd0);
        rd(4'd3, lo);
        rd(4'd4, hi);
        v = {hi, lo};
    endtask

    task automatic load64(input logic [63:0] v);
        wr(4'd7, v[31:0]);
        wr(4'd8, v[63:32]);
        wr(4'd9, 32'd0);
    endtask

    // Run with the given control word for K+1 active edges, then stop.
    task automatic run_for(input logic [31:0] ctl, input int k);
        wr(4'd0, ctl);
        repeat (k) @(negedge clk);
        wr(4'd0, ctl & ~32'h1);
    endtask

    initial begin
        logic [63:0] v, v2;
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd3, r); chk("R1 snap lo", r, 0);
        rd(4'd4, r); chk("R1 snap hi", r, 0);
        rd(4'd10, r); chk("R1 raw", r, 0);
        chk("R1 irq_level", irq_level, 0);
        chk("R1 irq_edge", irq_edge, 0);

        // R3 and R10: reload while stopped
        load64(64'h1234_5678_9abc_def0);
        snap(v); chk("R3 reload stopped", v, 64'h1234_5678_9abc_def0);
        repeat (20) @(negedge clk);
        snap(v); chk("R10 hold while stopped", v, 64'h1234_5678_9abc_def0);

        // R2 prescale sweep over every code
        for (int d = 0; d < 16; d++) begin
            int lim, k;
            lim = (d == 0) ? 16 : d;
            k = 2 * lim + (d % 3);
            wr(4'd0, 32'h0);
            load64(64'd0);
            wr(4'd1, d);
            run_for(32'h3, k);
            snap(v);
            chk($sformatf("R2 prescale %0d", d), v, 64'((k + 1) / lim));
        end

        // R4 down count and wrap through zero
        wr(4'd1, 32'd1);
        load64(64'd1);
        run_for(32'h1, 2);
        snap(v); chk("R4 down wrap", v, 64'hFFFF_FFFF_FFFF_FFFE);
        // R4 up carry across halves
        load64(64'h0000_0000_FFFF_FFFF);
        run_for(32'h3, 0);
        snap(v); chk("R4 up carry", v, 64'h0000_0001_0000_0000);
        // R4 down borrow across halves
        load64(64'h0000_0001_0000_0000);
        run_for(32'h1, 0);
        snap(v); chk("R4 down borrow", v, 64'h0000_0000_FFFF_FFFF);

        // R5 snapshot holds while counter moves
        load64(64'd100);
        snap(v);
        run_for(32'h3, 6);
        rd(4'd3, r); chk("R5 snap held", r, 100);
        snap(v2); chk("R5 new snap", v2, 64'd107);

        // R3 reload during run restarts from start value
        load64(64'd50);
        wr(4'd0, 32'h3);
        repeat (4) @(negedge clk);
        wr(4'd9, 32'd0);
        wr(4'd0, 32'h2);
        snap(v); chk("R3 reload while running", v, 64'd51);

        // R7, R8, R9: one-shot alarm
        wr(4'd11, 32'd1);
        wr(4'd13, 32'd1);
        wr(4'd5, 32'd3); wr(4'd6, 32'd0);
        load64(64'd0);
        edge_cnt = 0;
        wr(4'd0, 32'h3B);
        repeat (20) @(negedge clk);
        rd(4'd0, r);
        chk("R7 armed cleared", r[3], 0);
        chk("R7 still running", r[0], 1);
        wr(4'd0, 32'h32);
        repeat (3) @(negedge clk);
        chk("R9 one edge pulse", edge_cnt, 1);
        rd(4'd10, r); chk("R8 raw set", r, 1);
        rd(4'd12, r); chk("R8 status set", r, 1);
        chk("R8 level high", irq_level, 1);
        wr(4'd13, 32'd1);
        rd(4'd10, r); chk("R8 raw cleared", r, 0);
        chk("R8 level low", irq_level, 0);
        load64(64'd0);
        run_for(32'h33, 10);
        rd(4'd10, r); chk("R7 no refire", r, 0);
        chk("R7 no extra edge", edge_cnt, 1);

        // R6: periodic alarm, start 10, alarm 12, period 3 steps
        wr(4'd5, 32'd12);
        load64(64'd10);
        edge_cnt = 0;
        wr(4'd0, 32'h2F);
        repeat (14) @(negedge clk);
        rd(4'd0, r);
        wr(4'd0, 32'h2E);
        chk("R6 armed kept", r[3], 1);
        repeat (3) @(negedge clk);
        chk("R6 periodic alarm count", edge_cnt, 5);
        snap(v); chk("R6 reloaded count", v, 64'd11);
        wr(4'd13, 32'd1);

        // R8, R9: masked interrupt
        wr(4'd11, 32'd0);
        wr(4'd5, 32'd2);
        load64(64'd0);
        edge_cnt = 0;
        run_for(32'h3B, 8);
        repeat (3) @(negedge clk);
        rd(4'd10, r); chk("R8 masked raw", r, 1);
        rd(4'd12, r); chk("R8 masked status", r, 0);
        chk("R8 masked level", irq_level, 0);
        chk("R9 masked edge", edge_cnt, 0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule